// File: doc/BRIEF.md
# Address-Channel Command Legality Monitor

This block sits beside the write-address and read-address channels of a memory-controller AXI port and watches them without driving anything back. Whenever an address handshake completes (valid and ready both high in the same cycle), the command fields are tested against the narrow subset of AXI that the controller accepts. These are a single fixed beat size, incrementing bursts only, a short length limit that depends on the burst mode, zero in all user bits except the auto-precharge bit, a fixed protection code on reads, and an aligned column bit in pseudo-BL8 mode.

Every rule has a sticky flag per channel. A synchronous clear input resets the flags. For each offending command, the channel also gives a one-cycle report that carries the command ID and the set of rules it broke. A two-state summary machine shows whether any flag is set.

The summary machine has two states. It starts in `ST_CLEAN` after reset. It moves to `ST_FLAGGED` on any violating handshake (transition *raise*). It goes back to `ST_CLEAN` when the clear input is high and no violation arrives in the same cycle (transition *wipe*). In every other cycle it stays where it is (transitions *hold_clean* and *hold_flagged*).

Top module: `axi_cmd_legality_mon`

## Requirements
- R1: On a handshake, a size field other than 3'b101 sets rule bit 0.
- R2: On a handshake, a burst field other than 2'b01 (incrementing) sets rule bit 1.
- R3: With `mode_pbl8`=0 a length field above 1 sets rule bit 2. With `mode_pbl8`=1 any length other than exactly 1 sets rule bit 2.
- R4: A non-zero value in user bits 13:1 sets rule bit 3. User bit 0 is never checked.
- R5: On the read channel, a protection field other than 3'b010 sets rule bit 4. On the write channel the protection field is ignored, and write rule bit 4 stays 0.
- R6: With `mode_pbl8`=1, address bit `COL1_BIT` (default 6) set to 1 sets rule bit 5. With `mode_pbl8`=0 that bit is not checked.
- R7: Fields are judged only in a cycle where valid and ready are both high on that channel. Without a handshake, illegal fields change nothing.
- R8: In the cycle after a handshake that breaks at least one rule, the channel's hit output is high for one cycle. Its ID output carries the command ID and its rules output carries the broken-rule vector. After a legal handshake, or when no handshake took place, hit is 0 and the ID and rules outputs are 0.
- R9: Sticky rule bits accumulate until `err_clr` is sampled high, and then they clear. When a violation and a clear fall in the same cycle, the new violation's bits stay set.
- R10: After reset all flags, hit, ID and rules outputs and `any_err` are 0. From then on, `any_err` equals the OR of all sticky bits of both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pbl8 | input | 1 | 1 selects pseudo-BL8 rules, 0 selects BL4 rules |
| err_clr | input | 1 | Synchronous clear of all sticky flags |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_addr | input | 30 | Write address |
| aw_id | input | 7 | Write command ID |
| aw_len | input | 8 | Write burst length minus one |
| aw_size | input | 3 | Write beat size code |
| aw_burst | input | 2 | Write burst type |
| aw_prot | input | 3 | Write protection field (not checked) |
| aw_user | input | 14 | Write user bits |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_addr | input | 30 | Read address |
| ar_id | input | 7 | Read command ID |
| ar_len | input | 8 | Read burst length minus one |
| ar_size | input | 3 | Read beat size code |
| ar_burst | input | 2 | Read burst type |
| ar_prot | input | 3 | Read protection field |
| ar_user | input | 14 | Read user bits |
| wr_sticky | output | 6 | Sticky rule flags, write channel |
| rd_sticky | output | 6 | Sticky rule flags, read channel |
| wr_hit | output | 1 | One-cycle violation report, write channel |
| wr_hit_id | output | 7 | ID of the offending write command |
| wr_hit_rules | output | 6 | Rules broken by that write command |
| rd_hit | output | 1 | One-cycle violation report, read channel |
| rd_hit_id | output | 7 | ID of the offending read command |
| rd_hit_rules | output | 6 | Rules broken by that read command |
| any_err | output | 1 | High while any sticky flag is set |

## Verification
The bench targets these corner cases:
- **Protection field on writes.** A bad write protection value must leave every write flag clear. A design that checks it on both channels would raise write bit 4.
- **The two length rules.** A length of 0 is legal in BL4 but illegal in pseudo-BL8. Mixing up the rules shows as a missing or spurious bit 2.
- **Column bit in BL4.** A set column bit must raise nothing in BL4 mode.
- **Auto-precharge bit.** A set bit 0 in the user field must raise nothing, while a set bit 13 must.
- **Valid without ready.** Illegal fields that are valid but never accepted must not raise anything. A monitor that judges on valid alone flags commands that were never issued.
- **Clear and violation together.** When a clear and a violation fall in one cycle, the new bits must survive. A clear-first design loses them.

A behavioural model compares all outputs on every cycle, and a long randomized run with both channels active mixes these cases.

// File: rtl/axcl_pkg.sv
package axcl_pkg;

    localparam int ADDR_W    = 30;
    localparam int ID_W      = 7;
    localparam int LEN_W     = 8;
    localparam int USER_W    = 14;
    localparam int NUM_RULES = 6;
    localparam int NUM_CH    = 2;

    // rule bit positions (software-visible order of the flag vectors)
    localparam int RB_SIZE  = 0;
    localparam int RB_BURST = 1;
    localparam int RB_LEN   = 2;
    localparam int RB_USER  = 3;
    localparam int RB_PROT  = 4;
    localparam int RB_COL   = 5;

    localparam logic [2:0] SIZE_32B   = 3'b101;
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [2:0] PROT_REQ   = 3'b010;

    typedef logic [NUM_RULES-1:0] rules_t;

    typedef struct packed {
        logic              col1;
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [2:0]        size;
        logic [1:0]        burst;
        logic [2:0]        prot;
        logic [USER_W-1:0] user;
    } cmd_t;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FLAGGED = 1'b1
    } sum_state_t;

endpackage

// File: rtl/axcl_rule_eval.sv
module axcl_rule_eval
    import axcl_pkg::*;
#(
    parameter bit CHECK_PROT = 1'b1
) (
    input  cmd_t   cmd,
    input  logic   mode_pbl8,
    output rules_t bad
);

    localparam logic [USER_W-1:0] USER_MASK = ~{{(USER_W-1){1'b0}}, 1'b1};

    always_comb begin
        bad           = '0;
        bad[RB_SIZE]  = (cmd.size != SIZE_32B);
        bad[RB_BURST] = (cmd.burst != BURST_INCR);
        if (mode_pbl8) begin
            bad[RB_LEN] = (cmd.len != LEN_W'(1));
            bad[RB_COL] = cmd.col1;
        end else begin
            bad[RB_LEN] = (cmd.len > LEN_W'(1));
            bad[RB_COL] = 1'b0;
        end
        bad[RB_USER]  = |(cmd.user & USER_MASK);
        bad[RB_PROT]  = CHECK_PROT && (cmd.prot != PROT_REQ);
    end

endmodule

// File: rtl/axcl_chan_track.sv
module axcl_chan_track
    import axcl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            hs,
    input  logic [ID_W-1:0] id,
    input  rules_t          bad,
    output logic            set_evt,
    output rules_t          sticky,
    output logic            hit,
    output logic [ID_W-1:0] hit_id,
    output rules_t          hit_rules
);

    rules_t now_bad;

    always_comb begin
        now_bad = hs ? bad : '0;
        set_evt = |now_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky    <= '0;
            hit       <= 1'b0;
            hit_id    <= '0;
            hit_rules <= '0;
        end else begin
            sticky    <= (clr ? '0 : sticky) | now_bad;
            hit       <= set_evt;
            hit_id    <= set_evt ? id : '0;
            hit_rules <= now_bad;
        end
    end

    a_r7_no_hs_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> !hit);

    a_r8_hit_carries_id: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && set_evt) |=> (hit && hit_id == $past(id)));

    a_r9_sticky_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((sticky & $past(sticky)) == $past(sticky)));

    a_r9_clear_wins_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hs) |=> (sticky == '0));

endmodule

// File: rtl/axcl_status_fsm.sv
module axcl_status_fsm
    import axcl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_evt,
    output logic any_err
);

    sum_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAN:   if (set_evt)         state_nx = ST_FLAGGED; // raise
            ST_FLAGGED: if (clr && !set_evt) state_nx = ST_CLEAN;   // wipe
            default:                         state_nx = ST_CLEAN;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_CLEAN:   any_err = 1'b0;
            ST_FLAGGED: any_err = 1'b1;
            default:    any_err = 1'b0;
        endcase
    end

    a_r10_raise_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> any_err);

endmodule

// File: rtl/axi_cmd_legality_mon.sv
module axi_cmd_legality_mon
    import axcl_pkg::*;
#(
    parameter int COL1_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pbl8,
    input  logic              err_clr,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [2:0]        aw_size,
    input  logic [1:0]        aw_burst,
    input  logic [2:0]        aw_prot,
    input  logic [USER_W-1:0] aw_user,
    input  logic              ar_valid,
    input  logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [LEN_W-1:0]  ar_len,
    input  logic [2:0]        ar_size,
    input  logic [1:0]        ar_burst,
    input  logic [2:0]        ar_prot,
    input  logic [USER_W-1:0] ar_user,
    output logic [NUM_RULES-1:0] wr_sticky,
    output logic [NUM_RULES-1:0] rd_sticky,
    output logic              wr_hit,
    output logic [ID_W-1:0]   wr_hit_id,
    output logic [NUM_RULES-1:0] wr_hit_rules,
    output logic              rd_hit,
    output logic [ID_W-1:0]   rd_hit_id,
    output logic [NUM_RULES-1:0] rd_hit_rules,
    output logic              any_err
);

    localparam int CH_WR = 0;
    localparam int CH_RD = 1;

    cmd_t            cmd_a     [NUM_CH];
    logic            hs_a      [NUM_CH];
    rules_t          bad_a     [NUM_CH];
    logic            set_a     [NUM_CH];
    rules_t          sticky_a  [NUM_CH];
    logic            hit_a     [NUM_CH];
    logic [ID_W-1:0] hid_a     [NUM_CH];
    rules_t          hrules_a  [NUM_CH];

    always_comb begin
        cmd_a[CH_WR] = '{col1: aw_addr[COL1_BIT], id: aw_id, len: aw_len,
                         size: aw_size, burst: aw_burst, prot: aw_prot, user: aw_user};
        cmd_a[CH_RD] = '{col1: ar_addr[COL1_BIT], id: ar_id, len: ar_len,
                         size: ar_size, burst: ar_burst, prot: ar_prot, user: ar_user};
        hs_a[CH_WR]  = aw_valid && aw_ready;
        hs_a[CH_RD]  = ar_valid && ar_ready;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        axcl_rule_eval #(
            .CHECK_PROT ((g == CH_RD) ? 1'b1 : 1'b0)
        ) u_eval (
            .cmd       (cmd_a[g]),
            .mode_pbl8 (mode_pbl8),
            .bad       (bad_a[g])
        );

        axcl_chan_track u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (err_clr),
            .hs        (hs_a[g]),
            .id        (cmd_a[g].id),
            .bad       (bad_a[g]),
            .set_evt   (set_a[g]),
            .sticky    (sticky_a[g]),
            .hit       (hit_a[g]),
            .hit_id    (hid_a[g]),
            .hit_rules (hrules_a[g])
        );
    end

    axcl_status_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (err_clr),
        .set_evt (set_a[CH_WR] || set_a[CH_RD]),
        .any_err (any_err)
    );

    assign wr_sticky    = sticky_a[CH_WR];
    assign rd_sticky    = sticky_a[CH_RD];
    assign wr_hit       = hit_a[CH_WR];
    assign wr_hit_id    = hid_a[CH_WR];
    assign wr_hit_rules = hrules_a[CH_WR];
    assign rd_hit       = hit_a[CH_RD];
    assign rd_hit_id    = hid_a[CH_RD];
    assign rd_hit_rules = hrules_a[CH_RD];

    a_r10_summary_matches: assert property (@(posedge clk) disable iff (!rst_n)
        any_err == ((|wr_sticky) || (|rd_sticky)));

    a_r5_write_prot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready && aw_prot != PROT_REQ) |=> !wr_hit_rules[RB_PROT]);

    a_r6_col_free_in_bl4: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready && !mode_pbl8) |=> !rd_hit_rules[RB_COL]);

    a_r4_precharge_free: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready && aw_user == 14'd1) |=> !wr_hit_rules[RB_USER]);

endmodule

// File: tb/axi_cmd_legality_mon_tb_top.sv
module axi_cmd_legality_mon_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pbl8 = 1'b0;
    logic        err_clr = 1'b0;
    logic        aw_valid = 0, aw_ready = 0, ar_valid = 0, ar_ready = 0;
    logic [29:0] aw_addr = 0, ar_addr = 0;
    logic [6:0]  aw_id = 0, ar_id = 0;
    logic [7:0]  aw_len = 0, ar_len = 0;
    logic [2:0]  aw_size = 3'b101, ar_size = 3'b101;
    logic [1:0]  aw_burst = 2'b01, ar_burst = 2'b01;
    logic [2:0]  aw_prot = 3'b010, ar_prot = 3'b010;
    logic [13:0] aw_user = 0, ar_user = 0;
    logic [5:0]  wr_sticky, rd_sticky, wr_hit_rules, rd_hit_rules;
    logic        wr_hit, rd_hit, any_err;
    logic [6:0]  wr_hit_id, rd_hit_id;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit model_on = 0;

    always #4 clk = ~clk;

    axi_cmd_legality_mon dut_i (.*);

    // ---------------- behavioural reference model ----------------
    logic [5:0] m_sticky [2];
    logic       m_hit    [2];
    logic [6:0] m_id     [2];
    logic [5:0] m_rules  [2];

    function automatic logic [5:0] judge(bit is_rd, logic [29:0] a, logic [7:0] l,
            logic [2:0] s, logic [1:0] b, logic [2:0] p, logic [13:0] u, logic pb8);
        logic [5:0] r = 0;
        if (s != 3'b101) r[0] = 1;
        if (b != 2'b01) r[1] = 1;
        if (pb8) begin
            if (l != 1) r[2] = 1;
            if (a[6]) r[5] = 1;
        end else if (l > 1) r[2] = 1;
        if (u[13:1] != 0) r[3] = 1;
        if (is_rd && p != 3'b010) r[4] = 1;
        return r;
    endfunction

    always @(posedge clk) begin
        logic [5:0] bw, br;
        bw = (aw_valid && aw_ready) ?
             judge(0, aw_addr, aw_len, aw_size, aw_burst, aw_prot, aw_user, mode_pbl8) : 6'd0;
        br = (ar_valid && ar_ready) ?
             judge(1, ar_addr, ar_len, ar_size, ar_burst, ar_prot, ar_user, mode_pbl8) : 6'd0;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_sticky[c] = 0; m_hit[c] = 0; m_id[c] = 0; m_rules[c] = 0;
            end
        end else begin
            m_sticky[0] = (err_clr ? 6'd0 : m_sticky[0]) | bw;
            m_sticky[1] = (err_clr ? 6'd0 : m_sticky[1]) | br;
            m_hit[0] = |bw;  m_id[0] = (|bw) ? aw_id : 7'd0;  m_rules[0] = bw;
            m_hit[1] = |br;  m_id[1] = (|br) ? ar_id : 7'd0;  m_rules[1] = br;
        end
        cycles++;
    end

    function automatic string rule_tag(int i);
        case (i)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at t=%0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            for (int i = 0; i < 6; i++) begin
                cmp({rule_tag(i), " wr sticky"}, 32'(wr_sticky[i]), 32'(m_sticky[0][i]));
                cmp({rule_tag(i), " rd sticky"}, 32'(rd_sticky[i]), 32'(m_sticky[1][i]));
            end
            cmp("R8 wr hit", 32'(wr_hit), 32'(m_hit[0]));
            cmp("R8 wr id", 32'(wr_hit_id), 32'(m_id[0]));
            cmp("R8 wr rules", 32'(wr_hit_rules), 32'(m_rules[0]));
            cmp("R8 rd hit", 32'(rd_hit), 32'(m_hit[1]));
            cmp("R8 rd id", 32'(rd_hit_id), 32'(m_id[1]));
            cmp("R8 rd rules", 32'(rd_hit_rules), 32'(m_rules[1]));
            cmp("R10 any_err", 32'(any_err), 32'((|m_sticky[0]) || (|m_sticky[1])));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic legal_fields();
        aw_addr = 0; aw_len = 0; aw_size = 3'b101; aw_burst = 2'b01; aw_prot = 3'b010; aw_user = 0;
        ar_addr = 0; ar_len = 0; ar_size = 3'b101; ar_burst = 2'b01; ar_prot = 3'b010; ar_user = 0;
    endtask

    task automatic idle();
        aw_valid = 0; aw_ready = 0; ar_valid = 0; ar_ready = 0; err_clr = 0;
        legal_fields();
    endtask

    // fields already set by caller after posedge+1; take the edge, then go idle
    task automatic fire();
        @(posedge clk); #1;
        idle();
        @(negedge clk);
    endtask

    task automatic start();
        @(posedge clk); #1;
    endtask

    task automatic clear_all();
        start(); err_clr = 1; fire();
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        model_on = 1;
        // R10: reset state
        cmp("R10 reset sticky", 32'({wr_sticky, rd_sticky}), 0);
        cmp("R10 reset any", 32'(any_err), 0);

        // legal write, BL4 length 0
        start(); aw_valid = 1; aw_ready = 1; aw_id = 7'h11; fire();
        cmp("R8 legal no hit", 32'(wr_hit), 0);

        // R1 bad size
        start(); aw_valid = 1; aw_ready = 1; aw_id = 7'h21; aw_size = 3'b100; fire();
        cmp("R1 size flagged", 32'(wr_hit_rules), 32'h01);
        cmp("R8 id carried", 32'(wr_hit_id), 32'h21);
        clear_all();
        cmp("R9 cleared", 32'(wr_sticky), 0);

        // R2 wrap burst on read
        start(); ar_valid = 1; ar_ready = 1; ar_id = 7'h05; ar_burst = 2'b10; fire();
        cmp("R2 burst flagged", 32'(rd_hit_rules), 32'h02);
        clear_all();

        // R3 length rules
        start(); aw_valid = 1; aw_ready = 1; aw_len = 8'd2; fire();
        cmp("R3 BL4 len2", 32'(wr_hit_rules), 32'h04);
        start(); mode_pbl8 = 1; aw_valid = 1; aw_ready = 1; aw_len = 8'd0; fire();
        cmp("R3 pBL8 len0", 32'(wr_hit_rules), 32'h04);
        start(); aw_valid = 1; aw_ready = 1; aw_len = 8'd1; fire();
        cmp("R3 pBL8 len1 ok", 32'(wr_hit), 0);
        clear_all();

        // R6 column bit
        start(); ar_valid = 1; ar_ready = 1; ar_len = 1; ar_addr = 30'h40; fire();
        cmp("R6 pBL8 col set", 32'(rd_hit_rules), 32'h20);
        start(); mode_pbl8 = 0; ar_valid = 1; ar_ready = 1; ar_addr = 30'h40; fire();
        cmp("R6 BL4 col ignored", 32'(rd_hit), 0);
        clear_all();

        // R4 user bits
        start(); aw_valid = 1; aw_ready = 1; aw_user = 14'h0001; fire();
        cmp("R4 precharge free", 32'(wr_sticky), 0);
        start(); aw_valid = 1; aw_ready = 1; aw_user = 14'h2000; fire();
        cmp("R4 bit13 flagged", 32'(wr_hit_rules), 32'h08);
        clear_all();

        // R5 protection
        start(); aw_valid = 1; aw_ready = 1; aw_prot = 3'b000; fire();
        cmp("R5 write prot ignored", 32'(wr_sticky), 0);
        start(); ar_valid = 1; ar_ready = 1; ar_prot = 3'b000; ar_id = 7'h7f; fire();
        cmp("R5 read prot flagged", 32'(rd_hit_rules), 32'h10);
        cmp("R5 read id", 32'(rd_hit_id), 32'h7f);
        clear_all();

        // R7 valid without ready, ready without valid
        start(); aw_valid = 1; aw_size = 0; ar_ready = 1; ar_burst = 0; fire();
        cmp("R7 no handshake", 32'({wr_sticky, rd_sticky}), 0);
        cmp("R7 no summary", 32'(any_err), 0);

        // R9 set wins over clear; accumulation
        start(); aw_valid = 1; aw_ready = 1; aw_size = 0; fire();
        start(); aw_valid = 1; aw_ready = 1; aw_burst = 0; err_clr = 1; fire();
        cmp("R9 set beats clear", 32'(wr_sticky), 32'h02);
        start(); aw_valid = 1; aw_ready = 1; aw_len = 9; fire();
        cmp("R9 accumulate", 32'(wr_sticky), 32'h06);
        cmp("R10 any set", 32'(any_err), 1);
        clear_all();
        cmp("R10 any cleared", 32'(any_err), 0);

        // both channels in one cycle
        start(); aw_valid = 1; aw_ready = 1; aw_id = 3; aw_size = 1;
                 ar_valid = 1; ar_ready = 1; ar_id = 9; ar_user = 14'h4; fire();
        cmp("R8 dual wr", 32'({wr_hit, wr_hit_id}), 32'h83);
        cmp("R8 dual rd", 32'({rd_hit, rd_hit_id}), 32'h89);

        // randomized traffic, compared every cycle by the model
        for (int n = 0; n < 2000; n++) begin
            start();
            aw_valid = $urandom_range(0, 1); aw_ready = $urandom_range(0, 1);
            ar_valid = $urandom_range(0, 1); ar_ready = $urandom_range(0, 1);
            aw_id = 7'($urandom); ar_id = 7'($urandom);
            aw_addr = 30'($urandom); ar_addr = 30'($urandom);
            aw_len = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 1));
            ar_len = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 1));
            aw_size = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b101;
            ar_size = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b101;
            aw_burst = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b01;
            ar_burst = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b01;
            aw_prot = 3'($urandom);
            ar_prot = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b010;
            aw_user = ($urandom_range(0, 7) == 0) ? 14'($urandom) : 14'($urandom_range(0, 1));
            ar_user = ($urandom_range(0, 7) == 0) ? 14'($urandom) : 14'($urandom_range(0, 1));
            err_clr = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 63) == 0) mode_pbl8 = ~mode_pbl8;
        end
        start(); idle();
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule